// File: doc/BRIEF.md
# Packetized Data Transfer Engine with Per-Packet CRC

This block carries the data phase of a bulk transfer over a byte-wide link. On the sending side it takes a total byte count and a stream of payload bytes and cuts the payload into packets of a programmable power-of-two size. Each packet opens with a header byte that tells whether it is the first of several, an inner one, or the last (or only) one. When CRC protection is switched on, each packet is closed by a 16-bit CRC of its payload.

On the receiving side the engine consumes a byte stream for a transfer of known length. Before each packet it skips filler bytes until it finds a header, and it abandons the transfer if no header shows up within a bounded number of bytes. It passes the payload on and checks the trailing CRC. After each packet it produces a two-byte response: a tag byte carrying the packet type, then a status byte. A CRC mismatch makes the status non-zero and raises a sticky error flag.

Both sides latch the packet-size selector and the CRC enable when a transfer starts. A zero-length transfer request on either side is refused, and a one-cycle error pulse reports the refusal.

Top module: `pkt_stream_engine`

## Requirements
- R1: Every sent packet begins with a header byte 0xF0 | code, where code is 1 for the first of several packets, 2 for an inner packet, and 3 for the last packet or the only one.
- R2: The packet size is 2^(8+N) bytes, where N is cfgSizeSel. Values of N above 5 act as 5, giving sizes from 256 to 8192 bytes. Every packet except the last carries exactly that many payload bytes, and the last packet carries the remainder.
- R3: With cfgCrcEn high, each packet's payload is followed by CRC-ITU-T over that payload only, high byte first. The CRC uses polynomial 0x1021, seed 0xFFFF, MSB-first processing, and no reflection or final XOR. With cfgCrcEn low, the next header (or the end of the transfer) follows the payload directly.
- R4: A start request with a length of zero is refused. zeroLenErr is high for exactly the cycle after the request, no byte is emitted, and the busy output stays low.
- R5: A payload byte moves only when inValid and outReady are both high. While outValid is high and outReady is low, outValid and outData hold.
- R6: Before each packet, the receiver discards bytes whose upper nibble is not 0xF. Discarded bytes are never presented on payData.
- R7: After HUNT_LIMIT (default 100) consecutive discarded bytes, huntTimeout sets and the receiver returns to idle.
- R8: The receiver presents each payload byte on payData with payValid in the cycle it is accepted, in order, with packet lengths as in R2.
- R9: One cycle after a packet's last byte is accepted, rspValid is high for two consecutive cycles. The first byte is 0xC in the upper nibble and the header's low nibble in the lower nibble. The second byte is the status: 0x00 when the CRC matched or CRC is off, and 0x01 on a CRC mismatch.
- R10: crcErr sets on any CRC mismatch and stays set until the next accepted receive start.
- R11: Changes to cfgSizeSel or cfgCrcEn after a transfer starts have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSizeSel | input | 3 | Packet size selector N (size 2^(8+N)) |
| cfgCrcEn | input | 1 | Enable per-packet CRC-16 |
| zeroLenErr | output | 1 | Pulse: a zero-length start was refused |
| txStart | input | 1 | Start a send transfer |
| txLen | input | LEN_W | Total payload bytes to send |
| txBusy | output | 1 | Send transfer in progress |
| inData | input | 8 | Payload byte from the source |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Engine takes the source byte |
| outData | output | 8 | Outgoing link byte |
| outValid | output | 1 | Outgoing byte valid |
| outReady | input | 1 | Link accepts the byte |
| rxStart | input | 1 | Start a receive transfer |
| rxLen | input | LEN_W | Total payload bytes to receive |
| rxBusy | output | 1 | Receive transfer in progress |
| rxData | input | 8 | Incoming link byte |
| rxValid | input | 1 | Incoming byte valid |
| rxReady | output | 1 | Receiver accepts a byte |
| payData | output | 8 | Received payload byte |
| payValid | output | 1 | Received payload byte valid |
| rspData | output | 8 | Packet response byte |
| rspValid | output | 1 | Response byte valid |
| crcErr | output | 1 | Sticky CRC mismatch flag |
| huntTimeout | output | 1 | Sticky header-search timeout flag |

## Verification
Outgoing bytes and received payload bytes are combinational in the cycle of their handshake. The bench therefore drives inputs just after the falling edge and samples a moment later, before the rising edge that consumes them. The zero-length pulse and the timeout flag appear one cycle after the edge that caused them. The two response bytes fill the two cycles after the edge that took a packet's final byte. The bench reads each of these results at the falling edge of those exact cycles and compares it with streams, headers, CRCs and responses rebuilt arithmetically from the requirements.

// File: rtl/pkt_stream_pkg.sv
package pkt_stream_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HDR,
    SEL_PAY,
    SEL_CRCH,
    SEL_CRCL
  } outSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    load;
    logic    hdrGo;
    logic    payGo;
    outSel_e sel;
  } txStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pktEnd;
    logic lastByte;
    logic remZero;
    logic lenZero;
    logic crcOn;
  } txFlag_t;

  // one byte of CRC-ITU-T, MSB first
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  // packet size in bytes for a selector, clamped to the largest size
  function automatic int pktBytes(input int minLog, input int maxLog, input logic [2:0] sel);
    int s;
    s = int'(sel);
    if (s > maxLog - minLog) s = maxLog - minLog;
    return 1 << (minLog + s);
  endfunction

endpackage

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
  import pkt_stream_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txStart,
  input  logic      inValid,
  input  logic      outReady,
  input  txFlag_t   flags,
  output txStrobe_t strobes,
  output logic      outValid,
  output logic      inReady,
  output logic      txBusy,
  output logic      zeroLen
);

  typedef enum logic [2:0] {T_IDLE, T_HDR, T_PAY, T_CRCH, T_CRCL} txState_e;
  txState_e state, nextState;

  always_comb begin
    strobes   = '0;
    outValid  = 1'b0;
    inReady   = 1'b0;
    nextState = state;
    case (state)
      T_IDLE: begin
        strobes.load = txStart & ~flags.lenZero;
        if (txStart && !flags.lenZero) nextState = T_HDR;
      end
      T_HDR: begin
        strobes.sel = SEL_HDR;
        outValid    = 1'b1;
        if (outReady) begin
          strobes.hdrGo = 1'b1;
          nextState     = T_PAY;
        end
      end
      T_PAY: begin
        strobes.sel = SEL_PAY;
        outValid    = inValid;
        inReady     = outReady;
        if (inValid && outReady) begin
          strobes.payGo = 1'b1;
          if (flags.pktEnd) begin
            if (flags.crcOn)         nextState = T_CRCH;
            else if (flags.lastByte) nextState = T_IDLE;
            else                     nextState = T_HDR;
          end
        end
      end
      T_CRCH: begin
        strobes.sel = SEL_CRCH;
        outValid    = 1'b1;
        if (outReady) nextState = T_CRCL;
      end
      T_CRCL: begin
        strobes.sel = SEL_CRCL;
        outValid    = 1'b1;
        if (outReady) nextState = flags.remZero ? T_IDLE : T_HDR;
      end
      default: nextState = T_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= T_IDLE;
      zeroLen <= 1'b0;
    end else begin
      state   <= nextState;
      zeroLen <= (state == T_IDLE) & txStart & flags.lenZero;
    end
  end

  assign txBusy = (state != T_IDLE);

endmodule

// File: rtl/pkt_tx_dp.sv
module pkt_tx_dp
  import pkt_stream_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LOG = 8,
  parameter int MAX_LOG = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobes,
  input  logic [LEN_W-1:0] txLen,
  input  logic [2:0]       cfgSizeSel,
  input  logic             cfgCrcEn,
  input  logic [7:0]       inData,
  output txFlag_t          flags,
  output logic [7:0]       outData
);

  localparam int PKT_W = MAX_LOG + 1;

  logic [LEN_W-1:0] remLeft;
  logic [PKT_W-1:0] pktLeft;
  logic [15:0]      crcReg;
  logic             firstPkt;
  logic [2:0]       selL;
  logic             crcL;
  logic [LEN_W-1:0] pktSize;
  logic             remBig;
  logic [1:0]       orderCode;

  assign pktSize   = LEN_W'(pktBytes(MIN_LOG, MAX_LOG, selL));
  assign remBig    = remLeft > pktSize;
  assign orderCode = !remBig ? 2'd3 : (firstPkt ? 2'd1 : 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remLeft  <= '0;
      pktLeft  <= '0;
      crcReg   <= 16'hFFFF;
      firstPkt <= 1'b0;
      selL     <= '0;
      crcL     <= 1'b0;
    end else begin
      if (strobes.load) begin
        remLeft  <= txLen;
        selL     <= cfgSizeSel;
        crcL     <= cfgCrcEn;
        firstPkt <= 1'b1;
      end
      if (strobes.hdrGo) begin
        pktLeft  <= remBig ? PKT_W'(pktSize) : PKT_W'(remLeft);
        crcReg   <= 16'hFFFF;
        firstPkt <= 1'b0;
      end
      if (strobes.payGo) begin
        remLeft <= remLeft - 1'b1;
        pktLeft <= pktLeft - 1'b1;
        crcReg  <= crcStep(crcReg, inData);
      end
    end
  end

  always_comb begin
    case (strobes.sel)
      SEL_HDR:  outData = {6'b111100, orderCode};
      SEL_PAY:  outData = inData;
      SEL_CRCH: outData = crcReg[15:8];
      SEL_CRCL: outData = crcReg[7:0];
      default:  outData = 8'h00;
    endcase
  end

  assign flags.pktEnd   = (pktLeft == PKT_W'(1));
  assign flags.lastByte = (remLeft == LEN_W'(1));
  assign flags.remZero  = (remLeft == '0);
  assign flags.lenZero  = (txLen == '0);
  assign flags.crcOn    = crcL;

endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_stream_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MIN_LOG    = 8,
  parameter int MAX_LOG    = 13,
  parameter int HUNT_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgSizeSel,
  input  logic             cfgCrcEn,
  input  logic             rxStart,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  output logic             rxReady,
  output logic             rxBusy,
  output logic [7:0]       payData,
  output logic             payValid,
  output logic [7:0]       rspData,
  output logic             rspValid,
  output logic             crcErr,
  output logic             huntTimeout,
  output logic             zeroLen
);

  localparam int PKT_W  = MAX_LOG + 1;
  localparam int HUNT_W = $clog2(HUNT_LIMIT + 1);

  typedef enum logic [2:0] {R_IDLE, R_HUNT, R_PAY, R_CRCH, R_CRCL, R_RSP1, R_RSP2} rxState_e;
  rxState_e state;

  logic [LEN_W-1:0]  remLeft;
  logic [PKT_W-1:0]  pktLeft;
  logic [HUNT_W-1:0] huntCnt;
  logic [15:0]       crcReg;
  logic [7:0]        rcvHi;
  logic [3:0]        pktType;
  logic [2:0]        selL;
  logic              crcL;
  logic              pktBad;
  logic [LEN_W-1:0]  pktSize;
  logic              take;

  assign pktSize  = LEN_W'(pktBytes(MIN_LOG, MAX_LOG, selL));
  assign rxReady  = (state == R_HUNT) || (state == R_PAY) || (state == R_CRCH) || (state == R_CRCL);
  assign take     = rxValid & rxReady;
  assign rxBusy   = (state != R_IDLE);
  assign payValid = (state == R_PAY) & rxValid;
  assign payData  = rxData;
  assign rspValid = (state == R_RSP1) || (state == R_RSP2);
  assign rspData  = (state == R_RSP1) ? {4'hC, pktType} : {7'b0, pktBad};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= R_IDLE;
      remLeft     <= '0;
      pktLeft     <= '0;
      huntCnt     <= '0;
      crcReg      <= 16'hFFFF;
      rcvHi       <= '0;
      pktType     <= '0;
      selL        <= '0;
      crcL        <= 1'b0;
      pktBad      <= 1'b0;
      crcErr      <= 1'b0;
      huntTimeout <= 1'b0;
      zeroLen     <= 1'b0;
    end else begin
      zeroLen <= (state == R_IDLE) & rxStart & (rxLen == '0);
      case (state)
        R_IDLE: begin
          if (rxStart && rxLen != '0) begin
            remLeft     <= rxLen;
            selL        <= cfgSizeSel;
            crcL        <= cfgCrcEn;
            crcErr      <= 1'b0;
            huntTimeout <= 1'b0;
            huntCnt     <= '0;
            state       <= R_HUNT;
          end
        end
        R_HUNT: begin
          if (take) begin
            if (rxData[7:4] == 4'hF) begin
              pktType <= rxData[3:0];
              pktLeft <= (remLeft > pktSize) ? PKT_W'(pktSize) : PKT_W'(remLeft);
              crcReg  <= 16'hFFFF;
              pktBad  <= 1'b0;
              huntCnt <= '0;
              state   <= R_PAY;
            end else if (huntCnt == HUNT_W'(HUNT_LIMIT - 1)) begin
              huntTimeout <= 1'b1;
              state       <= R_IDLE;
            end else begin
              huntCnt <= huntCnt + 1'b1;
            end
          end
        end
        R_PAY: begin
          if (take) begin
            crcReg  <= crcStep(crcReg, rxData);
            remLeft <= remLeft - 1'b1;
            pktLeft <= pktLeft - 1'b1;
            if (pktLeft == PKT_W'(1)) state <= crcL ? R_CRCH : R_RSP1;
          end
        end
        R_CRCH: begin
          if (take) begin
            rcvHi <= rxData;
            state <= R_CRCL;
          end
        end
        R_CRCL: begin
          if (take) begin
            if ({rcvHi, rxData} != crcReg) begin
              pktBad <= 1'b1;
              crcErr <= 1'b1;
            end
            state <= R_RSP1;
          end
        end
        R_RSP1:  state <= R_RSP2;
        R_RSP2:  state <= (remLeft == '0) ? R_IDLE : R_HUNT;
        default: state <= R_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_stream_engine.sv
module pkt_stream_engine
  import pkt_stream_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MIN_LOG    = 8,
  parameter int MAX_LOG    = 13,
  parameter int HUNT_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgSizeSel,
  input  logic             cfgCrcEn,
  output logic             zeroLenErr,
  input  logic             txStart,
  input  logic [LEN_W-1:0] txLen,
  output logic             txBusy,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  input  logic             rxStart,
  input  logic [LEN_W-1:0] rxLen,
  output logic             rxBusy,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  output logic             rxReady,
  output logic [7:0]       payData,
  output logic             payValid,
  output logic [7:0]       rspData,
  output logic             rspValid,
  output logic             crcErr,
  output logic             huntTimeout
);

  txStrobe_t txStrobes;
  txFlag_t   txFlags;
  logic      zeroLenTx;
  logic      zeroLenRx;

  pkt_tx_ctrl u_txCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .txStart  (txStart),
    .inValid  (inValid),
    .outReady (outReady),
    .flags    (txFlags),
    .strobes  (txStrobes),
    .outValid (outValid),
    .inReady  (inReady),
    .txBusy   (txBusy),
    .zeroLen  (zeroLenTx)
  );

  pkt_tx_dp #(.LEN_W(LEN_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_txDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (txStrobes),
    .txLen      (txLen),
    .cfgSizeSel (cfgSizeSel),
    .cfgCrcEn   (cfgCrcEn),
    .inData     (inData),
    .flags      (txFlags),
    .outData    (outData)
  );

  pkt_rx #(.LEN_W(LEN_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .HUNT_LIMIT(HUNT_LIMIT)) u_rx (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSizeSel  (cfgSizeSel),
    .cfgCrcEn    (cfgCrcEn),
    .rxStart     (rxStart),
    .rxLen       (rxLen),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxReady     (rxReady),
    .rxBusy      (rxBusy),
    .payData     (payData),
    .payValid    (payValid),
    .rspData     (rspData),
    .rspValid    (rspValid),
    .crcErr      (crcErr),
    .huntTimeout (huntTimeout),
    .zeroLen     (zeroLenRx)
  );

  assign zeroLenErr = zeroLenTx | zeroLenRx;

endmodule

// File: rtl/pkt_stream_chk.sv
module pkt_stream_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txStart,
  input logic [LEN_W-1:0] txLen,
  input logic             txBusy,
  input logic [7:0]       outData,
  input logic             outValid,
  input logic             outReady,
  input logic             rxStart,
  input logic             rxBusy,
  input logic             rxValid,
  input logic             payValid,
  input logic [7:0]       rspData,
  input logic             rspValid,
  input logic             crcErr,
  input logic             huntTimeout
);

  assert_first_hdr_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> outValid && outData[7:4] == 4'hF && (outData[3:0] == 4'h1 || outData[3:0] == 4'h3));

  assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txBusy && txLen == '0) |=> !txBusy && !outValid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData));

  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(huntTimeout) |-> !rxBusy);

  assert_pay_only_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    payValid |-> rxValid && rxBusy);

  assert_rsp_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspData[7:4] == 4'hC) |=> rspValid && rspData[7:1] == 7'b0);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !rxStart) |=> crcErr);

  assert_err_with_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> rspValid && rspData[7:4] == 4'hC);

endmodule

bind pkt_stream_engine pkt_stream_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txStart     (txStart),
  .txLen       (txLen),
  .txBusy      (txBusy),
  .outData     (outData),
  .outValid    (outValid),
  .outReady    (outReady),
  .rxStart     (rxStart),
  .rxBusy      (rxBusy),
  .rxValid     (rxValid),
  .payValid    (payValid),
  .rspData     (rspData),
  .rspValid    (rspValid),
  .crcErr      (crcErr),
  .huntTimeout (huntTimeout)
);

// File: tb/tb_pkt_stream_engine.sv
module tb_pkt_stream_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int HUNT_LIMIT = 100;
  localparam int BUF_N      = 12288;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       cfgSizeSel = '0;
  logic             cfgCrcEn = 1'b0;
  logic             zeroLenErr;
  logic             txStart = 1'b0;
  logic [LEN_W-1:0] txLen = '0;
  logic             txBusy;
  logic [7:0]       inData = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [7:0]       outData;
  logic             outValid;
  logic             outReady = 1'b0;
  logic             rxStart = 1'b0;
  logic [LEN_W-1:0] rxLen = '0;
  logic             rxBusy;
  logic [7:0]       rxData = '0;
  logic             rxValid = 1'b0;
  logic             rxReady;
  logic [7:0]       payData;
  logic             payValid;
  logic [7:0]       rspData;
  logic             rspValid;
  logic             crcErr;
  logic             huntTimeout;

  int total = 0;
  int bad = 0;

  logic [7:0] stream [0:BUF_N-1];
  logic [1:0] kind   [0:BUF_N-1];
  int         pktOf  [0:BUF_N-1];
  logic [7:0] rspExp [0:127];
  int sLen;
  int rspN;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_stream_engine #(.LEN_W(LEN_W), .HUNT_LIMIT(HUNT_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .cfgSizeSel(cfgSizeSel), .cfgCrcEn(cfgCrcEn),
    .zeroLenErr(zeroLenErr), .txStart(txStart), .txLen(txLen), .txBusy(txBusy),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .rxStart(rxStart), .rxLen(rxLen), .rxBusy(rxBusy),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .payData(payData), .payValid(payValid), .rspData(rspData), .rspValid(rspValid),
    .crcErr(crcErr), .huntTimeout(huntTimeout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] srcByte(input int seed, input int i);
    return 8'((i * 37) + (seed * 11) + (i >> 8));
  endfunction

  function automatic logic [7:0] fillByte(input int k);
    return {4'(k % 15), 4'(k)};
  endfunction

  // table-free CRC-ITU-T, byte xored into the top
  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic buildStream(input int len, input int sel, input bit crcOn, input int seed);
    int rem, off, psz, n, pk;
    bit first;
    logic [15:0] c;
    logic [1:0] ord;
    logic [7:0] b;
    psz = 1 << (8 + ((sel > 5) ? 5 : sel));
    sLen = 0; rspN = 0; rem = len; off = 0; first = 1; pk = 0;
    while (rem > 0) begin
      n = (rem > psz) ? psz : rem;
      ord = (rem > psz) ? (first ? 2'd1 : 2'd2) : 2'd3;
      first = 0;
      stream[sLen] = {6'b111100, ord}; kind[sLen] = 2'd0; pktOf[sLen] = pk; sLen++;
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
        b = srcByte(seed, off + i);
        stream[sLen] = b; kind[sLen] = 2'd1; pktOf[sLen] = pk; sLen++;
        c = refCrc(c, b);
      end
      if (crcOn) begin
        stream[sLen] = c[15:8]; kind[sLen] = 2'd2; pktOf[sLen] = pk; sLen++;
        stream[sLen] = c[7:0];  kind[sLen] = 2'd2; pktOf[sLen] = pk; sLen++;
      end
      rspExp[rspN] = {6'b110000, ord}; rspExp[rspN + 1] = 8'h00; rspN += 2;
      off += n; rem -= n; pk++;
    end
  endtask

  // send side: R1 headers, R2 sizes, R3 CRC bytes, R5 stalls, R11 latched config
  task automatic runTx(input int len, input int sel, input bit crcOn, input int seed, input bit stall);
    int pos, srcIdx, guard;
    buildStream(len, sel, crcOn, seed);
    @(negedge clk);
    cfgSizeSel = 3'(sel); cfgCrcEn = crcOn; txLen = LEN_W'(len); txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    cfgSizeSel = 3'(sel + 1); cfgCrcEn = ~crcOn;   // R11: must not matter now
    pos = 0; srcIdx = 0; guard = 0;
    while (pos < sLen && guard < 40000) begin
      inValid  = 1'b1;
      inData   = srcByte(seed, srcIdx);
      outReady = stall ? ((guard % 3) != 1) : 1'b1;
      #1;
      if (outValid && outReady) begin
        case (kind[pos])
          2'd0:    chk("R1 header", outData, stream[pos]);
          2'd1:    chk("R2 payload", outData, stream[pos]);
          default: chk("R3 crc", outData, stream[pos]);
        endcase
        pos++;
      end
      if (inValid && inReady) srcIdx++;
      guard++;
      @(negedge clk);
    end
    inValid = 1'b0; outReady = 1'b0;
    #1;
    chk("R11 stream length", pos, sLen);
    chk("R5 source bytes taken", srcIdx, len);
    chk("R2 idle after last byte", txBusy, 1'b0);
  endtask

  // receive side: R6 fillers, R8 payload, R9 responses, R10 sticky error
  task automatic runRx(input int len, input int sel, input bit crcOn, input int seed,
                       input int fillers, input int corrupt);
    int j, r, guard, totalB, idx;
    bit expErr;
    logic expPay;
    buildStream(len, sel, crcOn, seed);
    expErr = 0;
    if (corrupt >= 0) begin
      stream[corrupt] = stream[corrupt] ^ 8'h10;
      if (crcOn) begin
        rspExp[2 * pktOf[corrupt] + 1] = 8'h01;
        expErr = 1;
      end
    end
    totalB = fillers + sLen;
    @(negedge clk);
    cfgSizeSel = 3'(sel); cfgCrcEn = crcOn; rxLen = LEN_W'(len); rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    cfgSizeSel = 3'(sel + 2); cfgCrcEn = ~crcOn;   // R11
    j = 0; r = 0; guard = 0;
    while ((j < totalB || r < rspN) && guard < 40000) begin
      if (j < totalB) begin
        rxValid = 1'b1;
        rxData  = (j < fillers) ? fillByte(j) : stream[j - fillers];
      end else begin
        rxValid = 1'b0;
      end
      #1;
      if (rxValid && rxReady) begin
        idx = j - fillers;
        if (j < fillers) begin
          chk("R6 filler not delivered", payValid, 1'b0);
        end else begin
          expPay = (kind[idx] == 2'd1);
          chk("R8 payValid", payValid, expPay);
          if (expPay) chk("R8 payData", payData, stream[idx]);
        end
        j++;
      end
      if (rspValid) begin
        if (r < rspN) chk("R9 response", rspData, rspExp[r]);
        else          chk("R9 extra response", 1'b1, 1'b0);
        r++;
      end
      guard++;
      @(negedge clk);
    end
    rxValid = 1'b0;
    #1;
    chk("R9 response count", r, rspN);
    chk("R8 idle after transfer", rxBusy, 1'b0);
    chk("R10 error flag", crcErr, expErr);
    chk("R7 no timeout", huntTimeout, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("reset txBusy", txBusy, 1'b0);
    chk("reset rxBusy", rxBusy, 1'b0);
    chk("reset outValid", outValid, 1'b0);
    chk("reset rspValid", rspValid, 1'b0);
    chk("reset flags", {crcErr, huntTimeout, zeroLenErr}, 3'b000);

    // R4: zero-length send refused
    @(negedge clk); txLen = '0; txStart = 1'b1;
    @(negedge clk); txStart = 1'b0; #1;
    chk("R4 tx zero pulse", zeroLenErr, 1'b1);
    chk("R4 tx stays idle", {txBusy, outValid}, 2'b00);
    @(negedge clk); #1;
    chk("R4 pulse one cycle", zeroLenErr, 1'b0);
    // R4: zero-length receive refused
    @(negedge clk); rxLen = '0; rxStart = 1'b1;
    @(negedge clk); rxStart = 1'b0; #1;
    chk("R4 rx zero pulse", zeroLenErr, 1'b1);
    chk("R4 rx stays idle", rxBusy, 1'b0);

    // near-exhaustive short lengths, both CRC settings (R1 R2 R3)
    for (int len = 1; len <= 12; len++) runTx(len, 0, len[0], len, len > 6);
    runTx(255, 0, 1, 3, 0);
    runTx(256, 0, 1, 4, 0);
    runTx(257, 0, 1, 5, 1);
    runTx(600, 0, 0, 6, 1);
    runTx(700, 0, 1, 7, 0);
    runTx(1200, 1, 1, 8, 1);
    runTx(1100, 2, 1, 9, 0);
    runTx(8193, 5, 0, 10, 0);
    runTx(9000, 6, 1, 11, 0);   // R2 clamp: selector 6 acts as 8192

    runRx(1, 0, 1, 20, 0, -1);
    runRx(300, 0, 1, 21, 3, -1);
    runRx(256, 0, 0, 22, 99, -1);     // R6: 99 fillers still within limit
    runRx(2000, 2, 1, 23, 1, -1);
    runRx(700, 0, 1, 24, 0, 300);     // R10: mismatch in second packet
    runRx(600, 1, 1, 25, 5, 10);      // R10: mismatch in first packet persists
    runRx(400, 0, 0, 26, 0, 5);       // R3: no CRC, no error

    // R7: header never arrives
    @(negedge clk); rxLen = LEN_W'(10); rxStart = 1'b1;
    @(negedge clk); rxStart = 1'b0;
    for (int k = 0; k < HUNT_LIMIT; k++) begin
      rxValid = 1'b1; rxData = fillByte(k);
      #1;
      chk("R6 hunting, no payload", payValid, 1'b0);
      if (k == HUNT_LIMIT - 1) chk("R7 not early", {huntTimeout, rxBusy}, 2'b01);
      @(negedge clk);
    end
    rxValid = 1'b0;
    #1;
    chk("R7 timeout set", huntTimeout, 1'b1);
    chk("R7 back to idle", rxBusy, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule